// File: doc/BRIEF.md
# Instruction Fetch Translation Checker

This block sits between an instruction fetch unit and an external translation lookaside buffer. For each fetch it takes a virtual address and a packed 64-bit machine-state word. It then decides one of three outcomes: the address passes straight through as a physical address, it is sent to the TLB for a lookup, or it is rejected with a fault. The checks run in a fixed order: bypass, alignment, address-hole range, a one-entry local translation cache, the TLB lookup, and finally page privilege. When the alignment, range or privilege check fails, the block updates its own fault status register. When a lookup misses, it records the faulting page and context in a tag-access register.

The TLB is outside the block. It accepts a lookup request in the request cycle and answers in the cycle that follows. A single-cycle `tlb_mod` pulse tells the checker that an entry was inserted or removed. That pulse discards the cached translation.

Top module: `itlb_xlate_chk`

## Requirements
- R1: When state bit 0 (hypervisor) or bit 1 (recovery mode) is set, the request is answered one cycle after acceptance with fault code 0 and `rsp_pa` equal to the low `PA_W` bits of the raw address. No lookup is issued.
- R2: Otherwise, a VA with bit 1 or bit 0 set is answered one cycle later with fault code 1. The status register is written with fault type 2. This check comes before the range check.
- R3: When state bit 3 is set, the VA is reduced to its low 32 bits and the range check is skipped. Otherwise a VA between `HOLE_LO` and `HOLE_HI` inclusive gives fault code 2 with fault type 4.
- R4: A non-zero trap level (state bits 18:16) selects context 0, context type 2 and ASI 0x04. A zero trap level selects context = state bits 44:32, context type 0 and ASI 0x80.
- R5: When state bit 4 (MMU enable) is clear, the lookup is a real lookup (`lkp_real`=1) with context 0. In every lookup, `lkp_req` rises in the request cycle, `lkp_part` = state bits 15:8 and `lkp_va` is the address after R3.
- R6: A lookup miss gives fault code 3 for a real lookup and 4 for a virtual one. It loads `tag_acc` with VA bits 63:13 above the 13-bit context, and it leaves the status register unchanged.
- R7: A hit on a privileged page while state bit 2 is clear gives fault code 2 with fault type 1.
- R8: A successful lookup responds two cycles after acceptance with `rsp_pa` = {`lkp_rsp_ppn`, VA bits 12:0} and fault code 0.
- R9: A status write sets bits 1:0 to 3 if the old bit 0 was set, and to 1 otherwise. It clears bits 2, 3 and 6. Bits 5:4 hold the context type, bits 15:7 the fault type and bits 23:16 the ASI.
- R10: `fsr_clr` zeroes the status register. If a status write happens in the same cycle, the old value counts as cleared, so bits 1:0 become 1.
- R11: A successful lookup fills the cache. A later request with an identical state word and the same VA page is then answered one cycle after acceptance from the cached page number, without a lookup.
- R12: `tlb_mod` empties the cache. If it is asserted in a request cycle, that request is not served from the cache. If it is asserted in either cycle of a lookup, that lookup does not fill the cache.
- R13: `req_ready` is low for the cycle that follows a lookup request, and `rsp_valid` stays low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Fetch translation request |
| req_ready | output | 1 | Block can accept a request |
| req_va | input | VA_W | Fetch virtual address |
| req_state | input | 64 | Packed machine-state word |
| lkp_req | output | 1 | TLB lookup request |
| lkp_va | output | VA_W | Lookup address |
| lkp_part | output | 8 | Lookup partition |
| lkp_ctx | output | 13 | Lookup context |
| lkp_real | output | 1 | Real (untranslated-context) lookup |
| lkp_rsp_hit | input | 1 | TLB hit, valid the cycle after `lkp_req` |
| lkp_rsp_ppn | input | PA_W-PAGE_BITS | Physical page number of the hit |
| lkp_rsp_priv | input | 1 | Hit page is privileged-only |
| tlb_mod | input | 1 | TLB contents changed |
| fsr_clr | input | 1 | Clear the fault status register |
| rsp_valid | output | 1 | Response pulse |
| rsp_pa | output | PA_W | Physical address |
| rsp_fault | output | 3 | 0 none, 1 misaligned, 2 access, 3 real miss, 4 virtual miss |
| fsr | output | 64 | Fault status register |
| tag_acc | output | VA_W | Tag-access register |

## Verification
The collision of interest is a `tlb_mod` pulse in the same cycle as a cache hit, or in the same cycle as a cache fill. The bench provokes it in both places. It raises the pulse in a request cycle whose state and page match the cached entry, and it expects a lookup instead of a one-cycle answer. It also raises the pulse in the answer cycle of a lookup, and it expects the next request for the same page to go out to the TLB again. The same bench also lands a status clear on the cycle of a fault write, and it expects bits 1:0 to read 1.

// File: rtl/itlb_chk_pkg.sv
package itlb_chk_pkg;

  localparam int CTX_W = 13;

  typedef enum logic [2:0] {
    FLT_NONE   = 3'd0,
    FLT_ALIGN  = 3'd1,
    FLT_ACCESS = 3'd2,
    FLT_RMISS  = 3'd3,
    FLT_VMISS  = 3'd4
  } flt_e;

  localparam logic [8:0] FT_PRIV  = 9'd1;
  localparam logic [8:0] FT_ALIGN = 9'd2;
  localparam logic [8:0] FT_RANGE = 9'd4;

  localparam logic [1:0] CT_PRIMARY = 2'd0;
  localparam logic [1:0] CT_NUCLEUS = 2'd2;

  localparam logic [7:0] ASI_PRIMARY = 8'h80;
  localparam logic [7:0] ASI_NUCLEUS = 8'h04;

  typedef struct packed {
    logic             hyp;
    logic             rmode;
    logic             priv;
    logic             amask;
    logic             mmu_on;
    logic [7:0]       part;
    logic [2:0]       tl;
    logic [CTX_W-1:0] pctx;
  } mstate_t;

  function automatic mstate_t unpack_state(input logic [63:0] w);
    mstate_t m;
    m.hyp    = w[0];
    m.rmode  = w[1];
    m.priv   = w[2];
    m.amask  = w[3];
    m.mmu_on = w[4];
    m.part   = w[15:8];
    m.tl     = w[18:16];
    m.pctx   = w[32 +: CTX_W];
    return m;
  endfunction

endpackage

// File: rtl/itlb_state_dec.sv
module itlb_state_dec
  import itlb_chk_pkg::*;
#(
  parameter int              VA_W    = 64,
  parameter logic [VA_W-1:0] HOLE_LO = '0,
  parameter logic [VA_W-1:0] HOLE_HI = '0
) (
  input  mstate_t          ms,
  input  logic [VA_W-1:0]  va,
  output logic             bypass,
  output logic             misalign,
  output logic             range_flt,
  output logic [VA_W-1:0]  va_eff,
  output logic [CTX_W-1:0] ctx,
  output logic             real_lkp,
  output logic [1:0]       ct,
  output logic [7:0]       asi
);
  logic nucleus;

  always_comb begin
    nucleus   = (ms.tl != 3'd0);
    bypass    = ms.hyp | ms.rmode;
    misalign  = (va[1:0] != 2'b00);
    va_eff    = ms.amask ? {{(VA_W-32){1'b0}}, va[31:0]} : va;
    range_flt = !ms.amask && (va >= HOLE_LO) && (va <= HOLE_HI);
    real_lkp  = !ms.mmu_on;
    ctx       = (nucleus || !ms.mmu_on) ? '0 : ms.pctx;
    ct        = nucleus ? CT_NUCLEUS : CT_PRIMARY;
    asi       = nucleus ? ASI_NUCLEUS : ASI_PRIMARY;
  end
endmodule

// File: rtl/itlb_fsr_build.sv
module itlb_fsr_build
  import itlb_chk_pkg::*;
(
  input  logic        prev_set,
  input  logic [1:0]  ct,
  input  logic [8:0]  ft,
  input  logic [7:0]  asi,
  output logic [63:0] value
);
  always_comb begin
    value        = '0;
    value[1:0]   = prev_set ? 2'b11 : 2'b01;
    value[2]     = 1'b0;
    value[5:4]   = ct;
    value[6]     = 1'b0;
    value[15:7]  = ft;
    value[23:16] = asi;
  end
endmodule

// File: rtl/itlb_xlate_cache.sv
module itlb_xlate_cache #(
  parameter int VPN_W = 51,
  parameter int PPN_W = 27
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inval,
  input  logic             fill,
  input  logic [63:0]      fill_state,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic [63:0]      look_state,
  input  logic [VPN_W-1:0] look_vpn,
  output logic             hit,
  output logic [PPN_W-1:0] hit_ppn
);
  logic             valid_q, valid_n;
  logic [63:0]      state_q;
  logic [VPN_W-1:0] vpn_q;
  logic [PPN_W-1:0] ppn_q;

  always_comb begin
    valid_n = valid_q;
    if (inval)     valid_n = 1'b0;
    else if (fill) valid_n = 1'b1;
    hit     = valid_q && (state_q == look_state) && (vpn_q == look_vpn);
    hit_ppn = ppn_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_n;
  end

  always_ff @(posedge clk) begin
    if (fill && !inval) begin
      state_q <= fill_state;
      vpn_q   <= fill_vpn;
      ppn_q   <= fill_ppn;
    end
  end
endmodule

// File: rtl/itlb_xlate_chk.sv
module itlb_xlate_chk
  import itlb_chk_pkg::*;
#(
  parameter int              VA_W      = 64,
  parameter int              PA_W      = 40,
  parameter int              PAGE_BITS = 13,
  parameter logic [VA_W-1:0] HOLE_LO   = VA_W'(64'h0000_8000_0000_0000),
  parameter logic [VA_W-1:0] HOLE_HI   = VA_W'(64'hFFFF_7FFF_FFFF_FFFF)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic [VA_W-1:0]           req_va,
  input  logic [63:0]               req_state,
  output logic                      lkp_req,
  output logic [VA_W-1:0]           lkp_va,
  output logic [7:0]                lkp_part,
  output logic [CTX_W-1:0]          lkp_ctx,
  output logic                      lkp_real,
  input  logic                      lkp_rsp_hit,
  input  logic [PA_W-PAGE_BITS-1:0] lkp_rsp_ppn,
  input  logic                      lkp_rsp_priv,
  input  logic                      tlb_mod,
  input  logic                      fsr_clr,
  output logic                      rsp_valid,
  output logic [PA_W-1:0]           rsp_pa,
  output logic [2:0]                rsp_fault,
  output logic [63:0]               fsr,
  output logic [VA_W-1:0]           tag_acc
);
  localparam int VPN_W = VA_W - PAGE_BITS;
  localparam int PPN_W = PA_W - PAGE_BITS;

  typedef enum logic {S_IDLE = 1'b0, S_WAIT = 1'b1} st_e;

  st_e st_q, st_n;

  mstate_t          ms;
  logic             d_bypass, d_misalign, d_range, d_real;
  logic [VA_W-1:0]  d_va;
  logic [CTX_W-1:0] d_ctx;
  logic [1:0]       d_ct;
  logic [7:0]       d_asi;

  logic [VA_W-1:0]  p_va;
  logic [CTX_W-1:0] p_ctx;
  logic             p_real, p_priv, p_inval;
  logic [1:0]       p_ct;
  logic [7:0]       p_asi;
  logic [63:0]      p_state;

  logic             c_hit;
  logic [PPN_W-1:0] c_ppn;
  logic             fill;

  logic             lkp_need, cap, rsp_set, fsr_we, tag_we;
  logic [PA_W-1:0]  pa_n;
  flt_e             flt_n;
  logic [8:0]       ft_n;
  logic [1:0]       ct_n;
  logic [7:0]       asi_n;
  logic [VA_W-1:0]  tag_n;
  logic [63:0]      fsr_built, fsr_n;

  logic             rsp_valid_q;
  logic [PA_W-1:0]  rsp_pa_q;
  flt_e             rsp_fault_q;
  logic [63:0]      fsr_q;
  logic [VA_W-1:0]  tag_q;

  assign ms = unpack_state(req_state);

  itlb_state_dec #(
    .VA_W(VA_W), .HOLE_LO(HOLE_LO), .HOLE_HI(HOLE_HI)
  ) u_dec (
    .ms(ms), .va(req_va),
    .bypass(d_bypass), .misalign(d_misalign), .range_flt(d_range),
    .va_eff(d_va), .ctx(d_ctx), .real_lkp(d_real), .ct(d_ct), .asi(d_asi)
  );

  itlb_xlate_cache #(.VPN_W(VPN_W), .PPN_W(PPN_W)) u_cache (
    .clk(clk), .rst_n(rst_n),
    .inval(tlb_mod), .fill(fill),
    .fill_state(p_state), .fill_vpn(p_va[VA_W-1:PAGE_BITS]), .fill_ppn(lkp_rsp_ppn),
    .look_state(req_state), .look_vpn(d_va[VA_W-1:PAGE_BITS]),
    .hit(c_hit), .hit_ppn(c_ppn)
  );

  itlb_fsr_build u_fsr (
    .prev_set(fsr_q[0] & ~fsr_clr), .ct(ct_n), .ft(ft_n), .asi(asi_n),
    .value(fsr_built)
  );

  // Decision logic: fixed order bypass, alignment, range, cache, lookup, privilege
  always_comb begin
    st_n     = st_q;
    lkp_need = 1'b0;
    cap      = 1'b0;
    rsp_set  = 1'b0;
    pa_n     = '0;
    flt_n    = FLT_NONE;
    fsr_we   = 1'b0;
    ft_n     = '0;
    ct_n     = d_ct;
    asi_n    = d_asi;
    tag_we   = 1'b0;
    tag_n    = '0;
    fill     = 1'b0;
    case (st_q)
      S_IDLE: begin
        if (req_valid) begin
          if (d_bypass) begin
            rsp_set = 1'b1;
            pa_n    = req_va[PA_W-1:0];
          end else if (d_misalign) begin
            rsp_set = 1'b1;
            flt_n   = FLT_ALIGN;
            fsr_we  = 1'b1;
            ft_n    = FT_ALIGN;
          end else if (d_range) begin
            rsp_set = 1'b1;
            flt_n   = FLT_ACCESS;
            fsr_we  = 1'b1;
            ft_n    = FT_RANGE;
          end else if (c_hit && !tlb_mod) begin
            rsp_set = 1'b1;
            pa_n    = {c_ppn, d_va[PAGE_BITS-1:0]};
          end else begin
            lkp_need = 1'b1;
            cap      = 1'b1;
            st_n     = S_WAIT;
          end
        end
      end
      S_WAIT: begin
        st_n    = S_IDLE;
        rsp_set = 1'b1;
        ct_n    = p_ct;
        asi_n   = p_asi;
        if (!lkp_rsp_hit) begin
          flt_n  = p_real ? FLT_RMISS : FLT_VMISS;
          tag_we = 1'b1;
          tag_n  = {p_va[VA_W-1:PAGE_BITS], PAGE_BITS'(p_ctx)};
        end else if (!p_priv && lkp_rsp_priv) begin
          flt_n  = FLT_ACCESS;
          fsr_we = 1'b1;
          ft_n   = FT_PRIV;
        end else begin
          pa_n = {lkp_rsp_ppn, p_va[PAGE_BITS-1:0]};
          fill = !tlb_mod && !p_inval;
        end
      end
      default: st_n = S_IDLE;
    endcase

    if (fsr_we)       fsr_n = fsr_built;
    else if (fsr_clr) fsr_n = '0;
    else              fsr_n = fsr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= S_IDLE;
      rsp_valid_q <= 1'b0;
      rsp_pa_q    <= '0;
      rsp_fault_q <= FLT_NONE;
      fsr_q       <= '0;
      tag_q       <= '0;
    end else begin
      st_q        <= st_n;
      rsp_valid_q <= rsp_set;
      if (rsp_set) begin
        rsp_pa_q    <= pa_n;
        rsp_fault_q <= flt_n;
      end
      if (fsr_we || fsr_clr) fsr_q <= fsr_n;
      if (tag_we)            tag_q <= tag_n;
    end
  end

  always_ff @(posedge clk) begin
    if (cap) begin
      p_va    <= d_va;
      p_ctx   <= d_ctx;
      p_real  <= d_real;
      p_priv  <= ms.priv;
      p_ct    <= d_ct;
      p_asi   <= d_asi;
      p_state <= req_state;
      p_inval <= tlb_mod;
    end
  end

  assign req_ready = (st_q == S_IDLE);
  assign lkp_req   = lkp_need;
  assign lkp_va    = d_va;
  assign lkp_part  = ms.part;
  assign lkp_ctx   = d_ctx;
  assign lkp_real  = d_real;
  assign rsp_valid = rsp_valid_q;
  assign rsp_pa    = rsp_pa_q;
  assign rsp_fault = rsp_fault_q;
  assign fsr       = fsr_q;
  assign tag_acc   = tag_q;
endmodule

// File: rtl/itlb_xlate_chk_sva.sv
module itlb_xlate_chk_sva
  import itlb_chk_pkg::*;
#(
  parameter int VA_W      = 64,
  parameter int PA_W      = 40,
  parameter int PAGE_BITS = 13
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic [VA_W-1:0] req_va,
  input logic [63:0]     req_state,
  input logic            lkp_req,
  input logic            fsr_clr,
  input logic            rsp_valid,
  input logic [PA_W-1:0] rsp_pa,
  input logic [2:0]      rsp_fault,
  input logic [63:0]     fsr,
  input logic [VA_W-1:0] tag_acc
);
  a_r1_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && (req_state[0] || req_state[1])) |=>
      (rsp_valid && rsp_fault == FLT_NONE && rsp_pa == $past(req_va[PA_W-1:0])));

  a_r1_no_lookup: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && (req_state[0] || req_state[1])) |-> !lkp_req);

  a_r2_align: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_state[0] && !req_state[1] && req_va[1:0] != 2'b00) |=>
      (rsp_valid && rsp_fault == FLT_ALIGN && fsr[0]));

  a_r13_busy: assert property (@(posedge clk) disable iff (!rst_n)
    lkp_req |=> (!req_ready && !rsp_valid));

  a_r8_latency: assert property (@(posedge clk) disable iff (!rst_n)
    lkp_req |-> ##2 rsp_valid);

  a_r6_real_ctx: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault == FLT_RMISS) |-> (tag_acc[PAGE_BITS-1:0] == '0));

  a_r9_fsr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(fsr_clr) && !(rsp_valid && (rsp_fault == FLT_ALIGN || rsp_fault == FLT_ACCESS)))
      |-> $stable(fsr));
endmodule

bind itlb_xlate_chk itlb_xlate_chk_sva #(
  .VA_W(VA_W), .PA_W(PA_W), .PAGE_BITS(PAGE_BITS)
) u_sva (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_va(req_va), .req_state(req_state), .lkp_req(lkp_req), .fsr_clr(fsr_clr),
  .rsp_valid(rsp_valid), .rsp_pa(rsp_pa), .rsp_fault(rsp_fault),
  .fsr(fsr), .tag_acc(tag_acc)
);

// File: tb/sim_itlb_xlate_chk.sv
module sim_itlb_xlate_chk;
  localparam logic [63:0] HLO = 64'h0000_8000_0000_0000;
  localparam logic [63:0] HHI = 64'hFFFF_7FFF_FFFF_FFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_va = '0;
  logic [63:0] req_state = '0;
  logic        lkp_req;
  logic [63:0] lkp_va;
  logic [7:0]  lkp_part;
  logic [12:0] lkp_ctx;
  logic        lkp_real;
  logic        lkp_rsp_hit = 1'b0;
  logic [26:0] lkp_rsp_ppn = '0;
  logic        lkp_rsp_priv = 1'b0;
  logic        tlb_mod = 1'b0;
  logic        fsr_clr = 1'b0;
  logic        rsp_valid;
  logic [39:0] rsp_pa;
  logic [2:0]  rsp_fault;
  logic [63:0] fsr;
  logic [63:0] tag_acc;

  int checks = 0;
  int errors = 0;

  // bench model state
  logic [63:0] m_fsr = '0;
  logic [63:0] m_tag = '0;
  logic        c_valid = 1'b0;
  logic [63:0] c_state = '0;
  logic [50:0] c_vpn = '0;
  logic [26:0] c_ppn = '0;

  always #5 clk = ~clk;

  itlb_xlate_chk u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_va(req_va), .req_state(req_state), .lkp_req(lkp_req), .lkp_va(lkp_va),
    .lkp_part(lkp_part), .lkp_ctx(lkp_ctx), .lkp_real(lkp_real),
    .lkp_rsp_hit(lkp_rsp_hit), .lkp_rsp_ppn(lkp_rsp_ppn), .lkp_rsp_priv(lkp_rsp_priv),
    .tlb_mod(tlb_mod), .fsr_clr(fsr_clr), .rsp_valid(rsp_valid), .rsp_pa(rsp_pa),
    .rsp_fault(rsp_fault), .fsr(fsr), .tag_acc(tag_acc)
  );

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  function automatic logic [63:0] fsr_val(input logic prev, input logic [1:0] ct,
                                          input logic [8:0] ft, input logic [7:0] asi);
    return {40'd0, asi, ft, 1'b0, ct, 1'b0, 1'b0, (prev ? 2'b11 : 2'b01)};
  endfunction

  function automatic logic [63:0] mk_state(input logic hyp, rm, pv, am, mmu,
                                           input logic [2:0] tl, input logic [7:0] part,
                                           input logic [15:0] pctx);
    return {16'h0, pctx, 13'h0, tl, part, 3'b0, mmu, am, pv, rm, hyp};
  endfunction

  task automatic run_case(input logic [63:0] s, input logic [63:0] va,
                          input logic hit, input logic ppriv, input logic [26:0] ppn,
                          input logic mod_req, input logic mod_wait, input logic clr);
    logic        nuc, e_look, e_chit, e_ok;
    logic [63:0] vm;
    logic [12:0] ctx;
    logic [1:0]  ct;
    logic [7:0]  asi;
    logic [2:0]  e_flt;
    logic [39:0] e_pa;
    logic [8:0]  e_ft;
    string       rq;
    nuc    = (s[18:16] != 3'd0);
    vm     = s[3] ? {32'h0, va[31:0]} : va;
    ctx    = (nuc || !s[4]) ? 13'h0 : s[44:32];
    ct     = nuc ? 2'd2 : 2'd0;
    asi    = nuc ? 8'h04 : 8'h80;
    e_chit = c_valid && (c_state == s) && (c_vpn == vm[63:13]) && !mod_req;
    e_look = 1'b0; e_ok = 1'b0; e_flt = 3'd0; e_pa = '0; e_ft = '0;
    if (s[0] || s[1]) begin
      rq = "R1"; e_pa = va[39:0];
    end else if (va[1:0] != 2'b00) begin
      rq = "R2"; e_flt = 3'd1; e_ft = 9'd2;
    end else if (!s[3] && va >= HLO && va <= HHI) begin
      rq = "R3"; e_flt = 3'd2; e_ft = 9'd4;
    end else if (e_chit) begin
      rq = "R11"; e_pa = {c_ppn, vm[12:0]};
    end else begin
      e_look = 1'b1;
      if (!hit) begin
        rq = "R6"; e_flt = s[4] ? 3'd4 : 3'd3;
        m_tag = {vm[63:13], ctx};
      end else if (!s[2] && ppriv) begin
        rq = "R7"; e_flt = 3'd2; e_ft = 9'd1;
      end else begin
        rq = "R8"; e_pa = {ppn, vm[12:0]}; e_ok = 1'b1;
      end
    end

    @(negedge clk);
    req_valid = 1'b1; req_va = va; req_state = s; tlb_mod = mod_req;
    fsr_clr = clr && !e_look;
    #1;
    chk(lkp_req == e_look, e_chit ? "R11" : "R5", "lkp_req", 64'(lkp_req), 64'(e_look));
    if (e_look) begin
      chk(lkp_ctx == ctx, "R4", "lkp_ctx", 64'(lkp_ctx), 64'(ctx));
      chk(lkp_real == !s[4], "R5", "lkp_real", 64'(lkp_real), 64'(!s[4]));
      chk(lkp_va == vm && lkp_part == s[15:8], "R5", "lkp_va", lkp_va, vm);
    end
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; tlb_mod = 1'b0; fsr_clr = 1'b0;
    if (e_look) begin
      chk(!req_ready && !rsp_valid, "R13", "busy", {62'd0, req_ready, rsp_valid}, 64'd0);
      lkp_rsp_hit = hit; lkp_rsp_ppn = ppn; lkp_rsp_priv = ppriv;
      tlb_mod = mod_wait; fsr_clr = clr;
      @(posedge clk);
      @(negedge clk);
      lkp_rsp_hit = 1'b0; lkp_rsp_priv = 1'b0; tlb_mod = 1'b0; fsr_clr = 1'b0;
    end
    // model updates
    if (e_ft != 9'd0)  m_fsr = fsr_val(m_fsr[0] && !clr, ct, e_ft, asi);
    else if (clr)      m_fsr = '0;
    if (mod_req || mod_wait) c_valid = 1'b0;
    if (e_ok && !mod_req && !mod_wait) begin
      c_valid = 1'b1; c_state = s; c_vpn = vm[63:13]; c_ppn = ppn;
    end
    chk(rsp_valid == 1'b1, rq, "rsp_valid", 64'(rsp_valid), 64'd1);
    chk(rsp_fault == e_flt, rq, "rsp_fault", 64'(rsp_fault), 64'(e_flt));
    if (e_flt == 3'd0) chk(rsp_pa == e_pa, rq, "rsp_pa", 64'(rsp_pa), 64'(e_pa));
    chk(fsr == m_fsr, (clr ? "R10" : "R9"), "fsr", fsr, m_fsr);
    chk(tag_acc == m_tag, "R6", "tag_acc", tag_acc, m_tag);
  endtask

  initial begin
    logic [63:0] s;
    logic [63:0] a;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!rsp_valid && req_ready && !lkp_req && fsr == '0 && tag_acc == '0, "R13",
        "reset state", {59'd0, rsp_valid, req_ready, lkp_req, (fsr != 0), (tag_acc != 0)}, 64'd8);

    // near-exhaustive sweep over state bits, alignment, range and TLB answer
    for (int i = 0; i < 2048; i++) begin
      logic [63:0] st;
      logic [63:0] va;
      st = mk_state(i[0], i[1], i[2], i[3], i[4], (i[5] ? 3'd5 : 3'd0),
                    8'(i * 3), 16'hA000 | 16'(i));
      va = (i[8] ? 64'hF008_0000_1234_5000 : 64'hC000_0012_3456_7000)
           + (64'(i >> 3) << 13) + 64'h100 + 64'(i[7:6]);
      run_case(st, va, i[9], i[10], 27'(i * 7 + 3), 1'b0, 1'b0, 1'b0);
    end

    // R11 / R12: cache hit and collisions with tlb_mod
    s = mk_state(0, 0, 1, 0, 1, 3'd0, 8'h11, 16'h0123);
    a = 64'h0000_0000_4000_2000;
    run_case(s, a, 1, 0, 27'h1234, 0, 0, 0);          // fill
    run_case(s, a + 8, 0, 0, 27'h0, 0, 0, 0);          // R11 served from cache
    run_case(s ^ 64'h100, a, 1, 0, 27'h0777, 0, 0, 0); // R11 other state: lookup
    run_case(s ^ 64'h100, a + 4, 0, 0, 27'h0, 1, 0, 0);// R12 mod in request: lookup miss
    run_case(s, a, 1, 0, 27'h2222, 0, 0, 0);           // refill
    run_case(s, a + 64'h2000, 1, 0, 27'h3333, 0, 1, 0);// R12 mod during wait: no fill
    run_case(s, a + 64'h2000, 1, 0, 27'h4444, 0, 0, 0);// R12 must look up again
    run_case(s, a + 64'h2010, 0, 0, 27'h0, 0, 0, 0);   // R11 hit on refilled page

    // R9 / R10: overflow and clear collisions
    s = mk_state(0, 0, 0, 0, 1, 3'd2, 8'h22, 16'h0055);
    run_case(s, 64'h1002, 0, 0, 27'h0, 0, 0, 1);       // R10 clear with fault
    run_case(s, 64'h1001, 0, 0, 27'h0, 0, 0, 0);       // R9 overflow bits 11
    run_case(s, 64'h1003, 0, 0, 27'h0, 0, 0, 1);       // R10 clear+fault: 01
    run_case(s | 64'h1, 64'h1003, 0, 0, 27'h0, 0, 0, 1); // R10 clear alone
    run_case(s, 64'h0000_0000_0000_4000, 1, 1, 27'h5, 0, 0, 1); // R7 with clear in wait

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 10);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule